// File: doc/BRIEF.md
# Synchronous delayed pulse generator

This block turns the rising edge of a clock-synchronous trigger into a single output pulse that appears after a programmable wait. The wait and the pulse length are set by two separate inputs and are counted in whole clock periods. The timing is therefore exactly as accurate as the clock, and no trimming is needed.

Internally, two down-counters are built from chained fixed-width stages, and both load synchronously. The first counter times the wait. When it reaches zero, its carry loads the second counter, which then times the pulse. A three-state controller (idle, waiting, pulsing) decides when each counter loads and runs. Every flop changes only on the clock edge. The reset is also sampled on the edge, so the block has no asynchronous set or clear.

Top module: `dpg_delay_pulse`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the block returns to idle and `pulse_o` is low after that edge. A sequence in progress is abandoned and produces no pulse.
- R2: Call E0 the rising edge at which `trig_i` is sampled high, having been sampled low at the previous edge, while the block is idle. With D equal to `dly_i` sampled at E0, `pulse_o` is first high in the clock period that follows edge E0+D. A value of D = 0 raises the pulse directly after E0.
- R3: With W equal to `wid_i` sampled at the edge where the pulse begins, `pulse_o` stays high for exactly W consecutive clock periods.
- R4: A width value of 0 gives a pulse of exactly one clock period.
- R5: One rising edge of the trigger gives exactly one pulse. Holding `trig_i` high for any length of time does not start a second sequence.
- R6: A trigger rise sampled while the block is waiting or pulsing is ignored. This includes a rise sampled at the edge that ends the pulse. A sequence cannot be shortened or restarted by the trigger.
- R7: The block is idle again in the clock period after the pulse ends. A rise sampled at the next edge starts a new sequence.
- R8: The delay and width values count exactly across the boundaries of the counter stages, for example at 16, 17, 255, 256 and 4096 with 4-bit stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low reset, sampled synchronously |
| trig_i | input | 1 | Synchronous trigger; its rising edge starts a sequence |
| dly_i | input | DLY_W | Wait, in clock periods, from detection to pulse start |
| wid_i | input | WID_W | Pulse length in clock periods (0 is treated as 1) |
| pulse_o | output | 1 | Registered output pulse |

## Verification
A controller stuck in the waiting or pulsing state shows at the ports as a missing pulse, a stretched pulse, or a later trigger that has no effect. The scoreboard reports this at the next expected pulse edge, within D+W cycles of the trigger. A borrow error between counter stages gives a pulse that starts late or early by a multiple of the stage span. Stage-crossing settings are therefore compared to the exact cycle. A failure to return to idle appears as a lost back-to-back trigger one cycle after the pulse ends. A spurious restart appears as an unexpected extra pulse, which the monitor flags as soon as it falls.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } dpg_state_e;
endpackage

// File: rtl/dpg_cnt_stage.sv
module dpg_cnt_stage #(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [SW-1:0] ld_val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [SW-1:0] q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     q <= '0;
    else if (ld_i)   q <= ld_val_i;
    else if (dec_i)  q <= q - 1'b1;
  end

  assign zero_o = (q == '0);
endmodule

// File: rtl/dpg_casc_cnt.sv
module dpg_casc_cnt #(
  parameter int CW = 16,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          en_i,
  output logic          carry_o
);
  localparam int NS = (CW + SW - 1) / SW;
  localparam int PW = NS * SW;

  logic [PW-1:0] ld_pad;
  logic [NS-1:0] zero;
  logic [NS:0]   low_zero;  // all stages below index are zero
  logic          run;

  assign ld_pad      = PW'(ld_val_i);
  assign low_zero[0] = 1'b1;
  assign carry_o     = low_zero[NS];
  assign run         = en_i & ~carry_o;  // hold at terminal count

  for (genvar i = 0; i < NS; i++) begin : g_stage
    assign low_zero[i+1] = low_zero[i] & zero[i];
    dpg_cnt_stage #(.SW(SW)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld_i),
      .ld_val_i (ld_pad[i*SW +: SW]),
      .dec_i    (run & low_zero[i]),
      .zero_o   (zero[i])
    );
  end
endmodule

// File: rtl/dpg_rise_det.sv
module dpg_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/dpg_delay_pulse.sv
module dpg_delay_pulse
  import dpg_pkg::*;
#(
  parameter int DLY_W   = 16,
  parameter int WID_W   = 16,
  parameter int STAGE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [WID_W-1:0] wid_i,
  output logic             pulse_o
);
  dpg_state_e state_q, state_d;

  logic             rise;
  logic             accept;
  logic             dly_zero;
  logic [DLY_W-1:0] dly_m1;
  logic [WID_W-1:0] wid_m1;
  logic             dly_ld, dly_carry;
  logic             wid_ld, wid_carry;
  logic             enter_pulse;
  logic             pulse_q;

  dpg_rise_det u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (trig_i),
    .rise_o (rise)
  );

  assign accept      = rise & (state_q == ST_IDLE);
  assign dly_zero    = (dly_i == '0);
  assign dly_m1      = dly_i - 1'b1;
  assign wid_m1      = (wid_i == '0) ? '0 : wid_i - 1'b1;
  assign dly_ld      = accept & ~dly_zero;
  assign enter_pulse = (accept & dly_zero) | ((state_q == ST_DELAY) & dly_carry);
  assign wid_ld      = enter_pulse;

  dpg_casc_cnt #(.CW(DLY_W), .SW(STAGE_W)) u_dly_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (dly_ld),
    .ld_val_i (dly_m1),
    .en_i     (state_q == ST_DELAY),
    .carry_o  (dly_carry)
  );

  dpg_casc_cnt #(.CW(WID_W), .SW(STAGE_W)) u_wid_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (wid_ld),
    .ld_val_i (wid_m1),
    .en_i     (state_q == ST_PULSE),
    .carry_o  (wid_carry)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept)    state_d = dly_zero ? ST_PULSE : ST_DELAY;
      ST_DELAY: if (dly_carry) state_d = ST_PULSE;
      ST_PULSE: if (wid_carry) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_d == ST_PULSE);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/dpg_delay_pulse_chk.sv
module dpg_delay_pulse_chk
  import dpg_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int WID_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic [DLY_W-1:0] dly_i,
  input logic [WID_W-1:0] wid_i,
  input logic             pulse_o,
  input dpg_state_e       state_q
);
  logic             trig_d, pulse_d, active;
  logic [DLY_W:0]   acc_cnt;
  logic [DLY_W-1:0] d_lat;
  logic [WID_W-1:0] w_d, w_lat;
  logic [WID_W:0]   run, w_exp;

  assign w_exp = (w_lat == '0) ? (WID_W+1)'(1) : {1'b0, w_lat};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trig_d <= 1'b0; pulse_d <= 1'b0; active <= 1'b0;
      acc_cnt <= '0; d_lat <= '0; w_d <= '0; w_lat <= '0; run <= '0;
    end else begin
      trig_d  <= trig_i;
      pulse_d <= pulse_o;
      w_d     <= wid_i;
      if (state_q == ST_IDLE && trig_i && !trig_d) begin
        active  <= 1'b1;
        acc_cnt <= '0;
        d_lat   <= dly_i;
      end else if (pulse_o) begin
        active  <= 1'b0;
      end else if (active) begin
        acc_cnt <= acc_cnt + 1'b1;
      end
      if (pulse_o && !pulse_d) begin
        run   <= (WID_W+1)'(1);
        w_lat <= w_d;
      end else if (pulse_o) begin
        run <= run + 1'b1;
      end
    end
  end

  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |=> !pulse_o);

  a_r2_delay_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> (active && acc_cnt == {1'b0, d_lat}));

  a_r3_width_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_d && !pulse_o) |-> (run == w_exp));

  a_r6_delay_not_aborted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DELAY) |=> (state_q != ST_IDLE));

  a_r7_idle_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_d && !pulse_o) |-> (state_q == ST_IDLE));
endmodule

bind dpg_delay_pulse dpg_delay_pulse_chk #(.DLY_W(DLY_W), .WID_W(WID_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .dly_i   (dly_i),
  .wid_i   (wid_i),
  .pulse_o (pulse_o),
  .state_q (state_q)
);

// File: tb/dpg_delay_pulse_tb_top.sv
`timescale 1ns/1ps
module dpg_delay_pulse_tb_top;
  localparam int DW = 16;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [DW-1:0] dly = '0;
  logic [WW-1:0] wid = '0;
  logic          pulse;

  always #2 clk = ~clk;

  dpg_delay_pulse #(.DLY_W(DW), .WID_W(WW), .STAGE_W(4)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .trig_i  (trig),
    .dly_i   (dly),
    .wid_i   (wid),
    .pulse_o (pulse)
  );

  typedef struct {
    int    start;
    int    width;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0, n_pulse = 0, n_exp = 0;
  int   st = 0;
  logic p_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: measure each pulse and compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse && !p_prev) st = cyc;
      if (!pulse && p_prev) begin
        n_pulse++;
        if (q.size() == 0) check(1'b0, "R6 unexpected pulse at cycle", st, -1);
        else begin
          e = q.pop_front();
          check(st == e.start, {e.tag, " start"}, st, e.start);
          check(cyc - st == e.width, {e.tag, " width"}, cyc - st, e.width);
        end
      end
    end
    p_prev = pulse;
  end

  // driver: raise trigger and push the expected pulse
  task automatic fire(input int d, input int w, input int hold, input string tag);
    exp_t x;
    @(negedge clk);
    dly  = DW'(d);
    wid  = WW'(w);
    trig = 1'b1;
    x.start = cyc + 1 + d;
    x.width = (w == 0) ? 1 : w;
    x.tag   = tag;
    q.push_back(x);
    n_exp++;
    repeat (hold) @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    finish_run();
  end

  initial begin
    int hi;
    repeat (4) @(negedge clk);
    check(pulse == 1'b0, "R1 low in reset", int'(pulse), 0);
    rst_n = 1'b1;
    hi = 0;
    repeat (5) begin @(negedge clk); if (pulse) hi++; end
    check(hi == 0, "R1 low after reset", hi, 0);

    fire(3, 2, 2, "R2 d3 w2");          wait_idle();
    fire(0, 1, 2, "R2 zero delay");     wait_idle();
    fire(0, 0, 2, "R4 zero width");     wait_idle();
    fire(5, 0, 3, "R4 d5 w0");          wait_idle();
    fire(1, 7, 2, "R3 d1 w7");          wait_idle();
    fire(16, 17, 2, "R8 stage cross");  wait_idle();
    fire(255, 256, 2, "R8 d255 w256");  wait_idle();
    fire(4096, 3, 2, "R8 d4096");       wait_idle();

    // R5: trigger held far beyond the sequence
    fire(2, 3, 40, "R5 held trigger");  wait_idle();

    // R6: rises during delay and during pulse are ignored
    fire(10, 4, 2, "R6 busy base");
    repeat (3) @(negedge clk);
    trig = 1'b1; repeat (2) @(negedge clk); trig = 1'b0;
    wait (pulse);
    @(negedge clk);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    wait_idle();

    // R6: rise sampled at the edge ending the pulse
    fire(2, 3, 2, "R6 last-cycle base");
    wait (pulse);
    repeat (3) @(negedge clk);
    trig = 1'b1; repeat (2) @(negedge clk); trig = 1'b0;
    wait_idle();

    // R7: new trigger right after the pulse ends
    fire(2, 3, 2, "R7 first");
    wait (pulse);
    wait (!pulse);
    fire(0, 2, 2, "R7 back to back");
    wait_idle();

    // R1: reset in the middle of a delay abandons the sequence
    @(negedge clk);
    dly = DW'(20); wid = WW'(5); trig = 1'b1;
    repeat (2) @(negedge clk);
    trig = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    hi = 0;
    repeat (40) begin @(negedge clk); if (pulse) hi++; end
    check(hi == 0, "R1 reset aborts sequence", hi, 0);

    repeat (10) @(negedge clk);
    check(n_pulse == n_exp, "R5 R6 pulse count", n_pulse, n_exp);
    check(q.size() == 0, "R2 pending pulses", q.size(), 0);
    finish_run();
  end
endmodule